// File: doc/BRIEF.md
# Burst Flash Host Bus Controller

This block sits between an on-chip requester and a parallel NOR-style flash device. The flash device has an address-valid strobe, and it can return data either asynchronously or as clocked bursts. The requester presents one request at a time. A request carries an address, a write flag, a burst flag, write data and a burst length. The block then runs the pin sequence the flash expects and returns each read word with a one-cycle valid strobe. It raises a done pulse when the access is finished.

The controller drives the following toward the device:

- chip enable, output enable and write enable, all active-low;
- the active-low address-valid strobe;
- the flash clock and the active-low device reset;
- the 24-bit address;
- the 16-bit outgoing data, together with a drive-enable for the bidirectional data bus.

All analogue timing is expressed as counts of the controller clock, given by parameters.

For an asynchronous access, the address is held steady with the strobe low for a setup phase. The strobe then rises while the address is unchanged, and that rising edge is where the flash captures the address. A burst read instead loads the start address over one full flash-clock period with the strobe low. It then streams one word per rising flash-clock edge, after a latency of a set number of edges. The flash advances its own internal address, so the controller keeps the start address on the bus. A synchronous reset ends any access at once and holds the device in reset for a set number of cycles.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and for RST_CYC (default 4) cycles after the last such edge, `fl_rst_n` is low. During that time chip enable, output enable, write enable and the address-valid strobe are all high, `fl_clk` is low and `fl_dq_oe` is low.
- R2: `req_ready` is high only when no access is in progress and the device reset time has run out. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` has no effect.
- R3: An asynchronous read or a write starts with SETUP_CYC (default 2) cycles with chip enable low, the strobe low, and output enable and write enable high. One cycle follows in which the strobe is high and everything else is unchanged. The address stays unchanged across the strobe's rising edge.
- R4: An asynchronous read then holds output enable low for W+1 cycles. W is the largest of T_OE−1, T_ACC−SETUP_CYC−2, T_CE−SETUP_CYC−2 and 1, which is 3 with the defaults. `fl_dq_in` is sampled in the last of those cycles, and `rsp_valid` is high for one cycle in the next cycle, with `rsp_data` equal to the sampled word.
- R5: A write (`req_write`=1, whatever `req_burst` is) follows the address phase with WP_CYC (default 3) cycles of write enable low and output enable high. In those cycles `fl_dq_oe` is high and `fl_dq_out` equals the request's write data. `fl_dq_oe` is low in every other cycle.
- R6: A burst read (`req_burst`=1, `req_write`=0) starts with two cycles of chip enable low and the strobe low. `fl_clk` is low in the first of these cycles and high in the second.
- R7: After the load, a burst read holds output enable low and the strobe high while `fl_clk` toggles every cycle, starting low. The first BURST_LAT (default 1) high cycles capture nothing. Each following high cycle captures one word, reported on `rsp_valid`/`rsp_data` in the next cycle, until `req_len`+1 words have been captured.
- R8: After the last captured read word, or after the last write-pulse cycle, chip enable goes high. The block spends REC_CYC (default 2) cycles with all controls inactive before it becomes ready. `done` is high in only the first of those cycles.
- R9: A reset at the clock edge that ends a burst word capture ends the burst. That word is never reported, and in the next cycle chip enable is high and the data bus is released.
- R10: Write enable and output enable are never low in the same cycle, and `fl_dq_oe` is high only while chip enable is low.
- R11: While chip enable is low, `fl_addr` equals the address of the request being served. This includes every cycle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = clocked burst read (reads only) |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| req_len | input | LEN_W (4) | Burst words minus one |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word |
| done | output | 1 | One-cycle access-complete pulse |
| fl_rst_n | output | 1 | Device reset, active low |
| fl_clk | output | 1 | Device burst clock |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_adv_n | output | 1 | Address-valid strobe, active low |
| fl_addr | output | 24 | Device address |
| fl_dq_out | output | 16 | Outgoing data bus value |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | 16 | Incoming data bus value |

## Verification
A burst word capture and a synchronous reset can meet at the same clock edge, and the reset must win. The bench starts a six-word burst and waits for the third rising flash-clock cycle that carries data. It raises reset in that cycle. The reference model then expects no response word in the following cycle, chip enable high, the bus released and the device reset low, and every pin is compared with the model on each cycle. A request that is already waiting while the device reset counter runs out is also covered: its acceptance must fall on the first ready cycle.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

    localparam int FB_ADDR_W = 24;
    localparam int FB_DATA_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_SETUP,
        S_ADDR_LATCH,
        S_OE_WAIT,
        S_CAPTURE,
        S_WRITE_PULSE,
        S_BURST_LOAD,
        S_BURST_DATA,
        S_RECOVER
    } fb_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic adv_n;
    } fb_ctl_t;

    typedef struct packed {
        logic                 wr;
        logic [FB_ADDR_W-1:0] addr;
        logic [FB_DATA_W-1:0] wdata;
    } fb_req_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Output-enable dwell so that the OE, address and enable access times are all met
    function automatic int rd_wait(input int t_oe, input int t_acc, input int t_ce, input int setup);
        int m;
        m = imax(1, t_oe - 1);
        m = imax(m, t_acc - setup - 2);
        m = imax(m, t_ce - setup - 2);
        return m;
    endfunction

    function automatic fb_ctl_t ctl_of(input fb_state_e s);
        fb_ctl_t c;
        c = '1;
        case (s)
            S_ADDR_SETUP, S_BURST_LOAD: begin
                c.ce_n = 1'b0; c.adv_n = 1'b0;
            end
            S_ADDR_LATCH: c.ce_n = 1'b0;
            S_OE_WAIT, S_CAPTURE, S_BURST_DATA: begin
                c.ce_n = 1'b0; c.oe_n = 1'b0;
            end
            S_WRITE_PULSE: begin
                c.ce_n = 1'b0; c.we_n = 1'b0;
            end
            default: c = '1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flash_wait_ctr.sv
module flash_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= '0;
        else if (load)
            val_q <= load_val;
        else if (dec && (val_q != '0))
            val_q <= val_q - 1'b1;
    end

    assign last = (val_q == '0);
endmodule

// File: rtl/flash_rst_gen.sv
module flash_rst_gen #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic dev_rst_n,
    output logic settled
);
    localparam int W = $clog2(CYC + 1);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= W'(CYC);
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign dev_rst_n = (hold_q == '0);
    assign settled   = (hold_q == '0);
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
    import flash_bus_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int RST_CYC   = 4,
    parameter int SETUP_CYC = 2,
    parameter int T_OE      = 3,
    parameter int T_ACC     = 7,
    parameter int T_CE      = 7,
    parameter int WP_CYC    = 3,
    parameter int REC_CYC   = 2,
    parameter int BURST_LAT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_burst,
    input  logic [23:0]          req_addr,
    input  logic [15:0]          req_wdata,
    input  logic [LEN_W-1:0]     req_len,
    output logic                 rsp_valid,
    output logic [15:0]          rsp_data,
    output logic                 done,
    output logic                 fl_rst_n,
    output logic                 fl_clk,
    output logic                 fl_ce_n,
    output logic                 fl_oe_n,
    output logic                 fl_we_n,
    output logic                 fl_adv_n,
    output logic [23:0]          fl_addr,
    output logic [15:0]          fl_dq_out,
    output logic                 fl_dq_oe,
    input  logic [15:0]          fl_dq_in
);
    localparam int RD_WAIT = rd_wait(T_OE, T_ACC, T_CE, SETUP_CYC);
    localparam int MAX_DUR = imax(imax(imax(SETUP_CYC, RD_WAIT), imax(WP_CYC, REC_CYC)),
                                  imax(BURST_LAT, 2));
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    fb_state_e         state_q, state_d;
    fb_req_t           rq_q;
    logic              ph_q, ph_d;
    logic [LEN_W-1:0]  left_q;
    logic              rsp_valid_q, done_q;
    logic [15:0]       rsp_data_q;
    logic              cnt_ld, cnt_dec, cnt_last;
    logic [CNT_W-1:0]  cnt_val;
    logic              accept, cap, settled;
    fb_ctl_t           ctl;

    flash_rst_gen #(.CYC(RST_CYC)) u_rst (
        .clk(clk), .rst(rst), .dev_rst_n(fl_rst_n), .settled(settled)
    );

    flash_wait_ctr #(.W(CNT_W)) u_wait (
        .clk(clk), .rst(rst), .load(cnt_ld), .load_val(cnt_val),
        .dec(cnt_dec), .last(cnt_last)
    );

    assign req_ready = (state_q == S_IDLE) && settled;

    always_comb begin
        state_d = state_q;
        ph_d    = 1'b0;
        cnt_ld  = 1'b0;
        cnt_val = '0;
        cnt_dec = 1'b0;
        accept  = 1'b0;
        cap     = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (req_valid && settled) begin
                    accept = 1'b1;
                    cnt_ld = 1'b1;
                    if (req_burst && !req_write) begin
                        state_d = S_BURST_LOAD;
                        cnt_val = CNT_W'(1);
                    end else begin
                        state_d = S_ADDR_SETUP;
                        cnt_val = CNT_W'(SETUP_CYC - 1);
                    end
                end
            end
            S_ADDR_SETUP: begin
                cnt_dec = 1'b1;
                if (cnt_last) state_d = S_ADDR_LATCH;
            end
            S_ADDR_LATCH: begin
                cnt_ld = 1'b1;
                if (rq_q.wr) begin
                    state_d = S_WRITE_PULSE;
                    cnt_val = CNT_W'(WP_CYC - 1);
                end else begin
                    state_d = S_OE_WAIT;
                    cnt_val = CNT_W'(RD_WAIT - 1);
                end
            end
            S_OE_WAIT: begin
                cnt_dec = 1'b1;
                if (cnt_last) state_d = S_CAPTURE;
            end
            S_CAPTURE: begin
                cap     = 1'b1;
                state_d = S_RECOVER;
                cnt_ld  = 1'b1;
                cnt_val = CNT_W'(REC_CYC - 1);
            end
            S_WRITE_PULSE: begin
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    state_d = S_RECOVER;
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(REC_CYC - 1);
                end
            end
            S_BURST_LOAD: begin
                ph_d    = ~ph_q;
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    state_d = S_BURST_DATA;
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(BURST_LAT);
                end
            end
            S_BURST_DATA: begin
                ph_d = ~ph_q;
                if (ph_q) begin
                    if (!cnt_last) begin
                        cnt_dec = 1'b1;
                    end else begin
                        cap = 1'b1;
                        if (left_q == '0) begin
                            state_d = S_RECOVER;
                            cnt_ld  = 1'b1;
                            cnt_val = CNT_W'(REC_CYC - 1);
                        end
                    end
                end
            end
            S_RECOVER: begin
                cnt_dec = 1'b1;
                if (cnt_last) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            ph_q        <= 1'b0;
            left_q      <= '0;
            rsp_valid_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            ph_q        <= ph_d;
            rsp_valid_q <= cap;
            done_q      <= (state_d == S_RECOVER) && (state_q != S_RECOVER);
            if (accept)
                left_q <= req_len;
            else if (cap && (left_q != '0))
                left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            rq_q.wr    <= req_write;
            rq_q.addr  <= req_addr;
            rq_q.wdata <= req_wdata;
        end
        if (cap)
            rsp_data_q <= fl_dq_in;
    end

    assign ctl       = ctl_of(state_q);
    assign fl_ce_n   = ctl.ce_n;
    assign fl_oe_n   = ctl.oe_n;
    assign fl_we_n   = ctl.we_n;
    assign fl_adv_n  = ctl.adv_n;
    assign fl_clk    = ph_q;
    assign fl_addr   = rq_q.addr;
    assign fl_dq_out = rq_q.wdata;
    assign fl_dq_oe  = (state_q == S_WRITE_PULSE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign done      = done_q;

    p_we_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));
    p_dq_needs_ce_r10: assert property (@(posedge clk) disable iff (rst)
        fl_dq_oe |-> !fl_ce_n);
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(fl_adv_n) && !fl_ce_n) |-> $stable(fl_addr));
    p_ready_rst_r2: assert property (@(posedge clk) disable iff (rst)
        !fl_rst_n |-> !req_ready);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_rsp_after_oe_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!fl_oe_n));
    p_clk_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        fl_clk |=> !fl_clk);
endmodule

// File: tb/tb_flash_bus_ctrl.sv
module tb_flash_bus_ctrl;
    localparam int CLK_P = 10;
    localparam int RST_CYC = 4, SETUP_CYC = 2, T_OE = 3, T_ACC = 7, T_CE = 7;
    localparam int WP_CYC = 3, REC_CYC = 2, BURST_LAT = 1;

    // {ce_n, oe_n, we_n, adv_n, fl_clk, dq_oe, done, capture}
    localparam logic [7:0] V_IDLE = 8'b1111_0000;
    localparam logic [7:0] V_AS   = 8'b0110_0000;
    localparam logic [7:0] V_AL   = 8'b0111_0000;
    localparam logic [7:0] V_OW   = 8'b0011_0000;
    localparam logic [7:0] V_CAP  = 8'b0011_0001;
    localparam logic [7:0] V_WP   = 8'b0101_0100;
    localparam logic [7:0] V_BL1  = 8'b0110_1000;
    localparam logic [7:0] V_BDH  = 8'b0011_1000;
    localparam logic [7:0] V_BDC  = 8'b0011_1001;
    localparam logic [7:0] V_RC1  = 8'b1111_0010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  req_len = '0;
    logic [15:0] fl_dq_in = '0;
    logic req_ready, rsp_valid, done, fl_rst_n, fl_clk, fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, fl_dq_oe;
    logic [15:0] rsp_data, fl_dq_out;
    logic [23:0] fl_addr;

    always #(CLK_P/2) clk = ~clk;

    flash_bus_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_len(req_len), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .done(done), .fl_rst_n(fl_rst_n), .fl_clk(fl_clk),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_adv_n(fl_adv_n),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] q[$];
    string      tq[$];
    int   rl = 0;
    bit   armed = 0, cur_busy = 0, cur_cap = 0, ready_now = 0, accepted = 0;
    bit   pend = 0;
    logic [15:0] pend_data = '0;
    string pend_tag = "R4";
    logic [23:0] cur_addr = '0;
    logic [15:0] cur_wdata = '0;
    bit d_rst = 1, d_valid = 0, d_wr = 0, d_burst = 0;
    logic [23:0] d_addr = '0;
    logic [15:0] d_wdata = '0;
    logic [3:0]  d_len = '0;

    function automatic int rd_wait_exp();
        int m;
        m = 1;
        if (T_OE - 1 > m) m = T_OE - 1;
        if (T_ACC - SETUP_CYC - 2 > m) m = T_ACC - SETUP_CYC - 2;
        if (T_CE - SETUP_CYC - 2 > m) m = T_CE - SETUP_CYC - 2;
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v, input string t);
        q.push_back(v);
        tq.push_back(t);
    endtask

    task automatic push_trace(input bit wr, input bit burst, input int len);
        if (burst && !wr) begin
            push(V_AS, "R6"); push(V_BL1, "R6");
            for (int i = 0; i < BURST_LAT; i++) begin push(V_OW, "R7"); push(V_BDH, "R7"); end
            for (int w = 0; w <= len; w++) begin push(V_OW, "R7"); push(V_BDC, "R7"); end
        end else begin
            for (int i = 0; i < SETUP_CYC; i++) push(V_AS, "R3");
            push(V_AL, "R3");
            if (wr) begin
                for (int i = 0; i < WP_CYC; i++) push(V_WP, "R5");
            end else begin
                for (int i = 0; i < rd_wait_exp(); i++) push(V_OW, "R4");
                push(V_CAP, "R4");
            end
        end
        push(V_RC1, "R8");
        for (int i = 1; i < REC_CYC; i++) push(V_IDLE, "R8");
    endtask

    task automatic observe();
        logic [7:0] e;
        string t;
        logic [6:0] act;
        @(negedge clk);
        cyc++;
        fl_dq_in = 16'h3c00 ^ 16'(cyc * 16'h0131);
        cur_cap = 0;
        if (!armed) return;
        cur_busy = (q.size() > 0);
        if (cur_busy) begin e = q.pop_front(); t = tq.pop_front(); end
        else begin e = V_IDLE; t = (rl > 0) ? "R1" : "R8"; end
        act = {fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, fl_clk, fl_dq_oe, done};
        chk(act == e[7:1], t, 32'(act), 32'(e[7:1]));
        cur_cap = e[0];
        chk(fl_rst_n == (rl == 0), "R1", 32'(fl_rst_n), 32'(rl == 0));
        ready_now = !cur_busy && (rl == 0);
        chk(req_ready == ready_now, "R2", 32'(req_ready), 32'(ready_now));
        if (!fl_ce_n) chk(fl_addr == cur_addr, "R11", 32'(fl_addr), 32'(cur_addr));
        if (fl_dq_oe) chk(fl_dq_out == cur_wdata, "R5", 32'(fl_dq_out), 32'(cur_wdata));
        chk(rsp_valid == pend, pend_tag, 32'(rsp_valid), 32'(pend));
        if (pend) chk(rsp_data == pend_data, pend_tag, 32'(rsp_data), 32'(pend_data));
    endtask

    task automatic drive();
        rst = d_rst; req_valid = d_valid; req_write = d_wr; req_burst = d_burst;
        req_addr = d_addr; req_wdata = d_wdata; req_len = d_len;
        accepted = 0;
        if (d_rst) begin
            q.delete(); tq.delete();
            rl = RST_CYC; pend = 0; armed = 1;
        end else begin
            if (rl > 0) rl--;
            pend = cur_cap;
            pend_data = fl_dq_in;
            pend_tag = (tq.size() > 0 && tq[0] == "R7") || q.size() == 0 ? "R7" : "R4";
            if (d_valid && ready_now) begin
                accepted = 1;
                cur_addr = d_addr; cur_wdata = d_wdata;
                push_trace(d_wr, d_burst, int'(d_len));
            end
        end
    endtask

    task automatic tick();
        observe();
        drive();
    endtask

    task automatic issue(input bit wr, input bit burst, input logic [23:0] a,
                         input logic [15:0] wd, input logic [3:0] len);
        d_wr = wr; d_burst = burst; d_addr = a; d_wdata = wd; d_len = len; d_valid = 1;
        for (int g = 0; g < 500; g++) begin
            tick();
            if (accepted) break;
        end
        if (!accepted) chk(0, "R2", 0, 1);
        d_valid = 0;
    endtask

    initial begin
        #(CLK_P * 20000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset, then a request already waiting while device reset runs out (R2)
        observe(); drive();
        d_rst = 0;
        issue(0, 0, 24'h12_3456, 16'h0000, 4'd0);          // R3 R4 async read
        issue(1, 0, 24'hAB_CDE0, 16'hBEEF, 4'd0);          // R5 write, back to back
        issue(1, 1, 24'h00_0040, 16'h1234, 4'd2);          // R5 write with burst flag ignored
        issue(0, 1, 24'h00_0100, 16'h0000, 4'd3);          // R6 R7 four-word burst
        issue(0, 1, 24'hFF_FFFE, 16'h0000, 4'd0);          // R7 single-word burst
        issue(0, 0, 24'hFF_FFFF, 16'h0000, 4'd0);          // R4 read at top address
        for (int i = 0; i < 24; i++) tick();               // R8 idle afterwards
        // R9: reset on the edge that captures the third burst word
        issue(0, 1, 24'h55_0000, 16'h0000, 4'd5);
        begin
            int caps;
            caps = 0;
            for (int g = 0; g < 100; g++) begin
                observe();
                if (cur_cap) caps++;
                if (cur_cap && caps == 3) begin d_rst = 1; drive(); break; end
                drive();
            end
            d_rst = 0;
            observe();
            chk(fl_ce_n == 1'b1, "R9", 32'(fl_ce_n), 1);
            chk(rsp_valid == 1'b0, "R9", 32'(rsp_valid), 0);
            chk(fl_dq_oe == 1'b0, "R9", 32'(fl_dq_oe), 0);
            drive();
        end
        issue(1, 0, 24'h00_0002, 16'hA5C3, 4'd0);          // R5 after reset
        issue(0, 0, 24'h80_0001, 16'h0000, 4'd0);          // R4
        issue(0, 1, 24'h0F_0F0F, 16'h0000, 4'd15);         // R7 longest burst
        for (int i = 0; i < 20; i++) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule